// File: doc/BRIEF.md
# UART Interrupt Priority Controller

This block collects every interrupt condition a UART can raise and presents only the most urgent one to the host. There are seven sources: receive line errors, receive time-out, receive data, transmit space, modem pin change, flow or special character, and the CTS/RTS pin deassertion. Each belongs to an enable group. The block drives an active-low request pin. It also provides a 6-bit identification code that says which source is being served. The priority choice is made by combinational logic from the current pending set, so a change on a level source reaches the pin and the code in the same cycle.

Four sources are edge events, and each is held in its own sticky flag until its clear condition occurs:

- A modem change clears on a modem-status read.
- An Xoff detection clears only on an Xon detection.
- A special-character detection clears on an identification read, but only while that code is on display.
- A CTS or RTS deassertion clears on a flow-pin status read.

In every flag, a set in the same cycle as a clear wins.

The block has no data stream; all of its pins are plain control and status levels or one-cycle strobes.

Top module: `uart_irq_arbiter`

## Requirements
- R1: With no enabled source pending, `iir_code` is 6'b000001 and `irq_n` is 1; this is also the state during and just after reset.
- R2: A line-status condition (`rx_overrun` or `rx_err_any` high) with `irq_en[0]` set yields code 6'b000110, ahead of every other source.
- R3: With `irq_en[1]` set, an RX time-out (`rx_timeout`) yields code 6'b001100 and wins over pending receive data (6'b000100) and all lower sources.
- R4: The receive-data source is `rx_ready` when `fifo_en` is 0 and `rx_lvl_hit` when `fifo_en` is 1; with `irq_en[1]` set it yields code 6'b000100.
- R5: The transmit source is `tx_empty` when `fifo_en` is 0 and `tx_lvl_hit` when `fifo_en` is 1; with `irq_en[2]` set it yields code 6'b000010.
- R6: A `modem_chg` pulse sets a sticky flag, reported as code 6'b000000 under `irq_en[3]`. The flag is cleared by `msr_rd`; a set and a clear in the same cycle leave it set.
- R7: An `xoff_det` pulse sets a sticky flag reported as code 6'b010000 under `irq_en[4]`. Only `xon_det` clears it; `iir_rd` has no effect on it.
- R8: A `spchar_det` pulse sets a sticky flag reported as code 6'b010000 under `irq_en[4]`. It is cleared by `iir_rd` only in a cycle where `iir_code` shows 6'b010000; an `iir_rd` while a higher source is shown leaves it set.
- R9: A `cts_deassert` or `rts_deassert` pulse sets a sticky flag reported as code 6'b100000 under `irq_en[5]`; `flow_rd` clears it.
- R10: A source whose enable bit is 0 does not affect `irq_n` or `iir_code`. A sticky flag still records events while its enable bit is 0, and it is reported as soon as the bit is set.
- R11: Results from level sources appear on `irq_n` and `iir_code` in the same cycle, with no register in the path. Sticky sources appear one clock after their pulse is sampled. `irq_n` is 0 exactly when `iir_code` is not 6'b000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 6 | Enables: [0] line, [1] RX time-out and data, [2] TX, [3] modem, [4] Xoff/special, [5] CTS/RTS |
| fifo_en | input | 1 | Selects the FIFO-mode level sources for RX data and TX |
| rx_overrun | input | 1 | Receive overrun, level |
| rx_err_any | input | 1 | A framing, parity or break error exists anywhere in the receive FIFO, level |
| rx_timeout | input | 1 | Stale data sits in the receive FIFO, level |
| rx_ready | input | 1 | Receive character ready (non-FIFO mode), level |
| rx_lvl_hit | input | 1 | Receive FIFO above its trigger level, level |
| tx_empty | input | 1 | Transmit holding empty (non-FIFO mode), level |
| tx_lvl_hit | input | 1 | Transmit FIFO has passed its trigger threshold, level |
| modem_chg | input | 1 | Modem input change, pulse |
| xoff_det | input | 1 | Xoff character detected, pulse |
| xon_det | input | 1 | Xon character detected, pulse |
| spchar_det | input | 1 | Special character detected, pulse |
| cts_deassert | input | 1 | CTS went from active low to inactive high, pulse |
| rts_deassert | input | 1 | RTS went from active low to inactive high, pulse |
| iir_rd | input | 1 | Identification register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| flow_rd | input | 1 | Flow-pin status register read strobe |
| irq_n | output | 1 | Interrupt request, active low |
| iir_code | output | 6 | Code of the highest-priority enabled pending source |

## Verification
The bench builds the block with its default parameters: seven tiers and 6-bit codes. This makes every tier, every code and every enable bit reachable. A vector table covers the level sources across both `fifo_en` settings and partial enable masks. It includes the tie inside tier two and the line-status override. Directed sequences then cover each sticky flag's own clear rule. These include a set colliding with a clear, an identification read issued while a higher source hides the special character, and an event recorded while its enable is off.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int unsigned CODE_W = 6;
  localparam int unsigned TIERS  = 7;
  localparam int unsigned EN_W   = 6;

  typedef logic [CODE_W-1:0] iir_code_t;

  localparam iir_code_t CODE_NONE   = 6'b000001;
  localparam iir_code_t CODE_LINE   = 6'b000110;
  localparam iir_code_t CODE_RXTO   = 6'b001100;
  localparam iir_code_t CODE_RXDATA = 6'b000100;
  localparam iir_code_t CODE_TX     = 6'b000010;
  localparam iir_code_t CODE_MODEM  = 6'b000000;
  localparam iir_code_t CODE_FLOW   = 6'b010000;
  localparam iir_code_t CODE_PIN    = 6'b100000;

  // enable bit positions
  localparam int unsigned EN_LINE  = 0;
  localparam int unsigned EN_RX    = 1;
  localparam int unsigned EN_TX    = 2;
  localparam int unsigned EN_MODEM = 3;
  localparam int unsigned EN_FLOW  = 4;
  localparam int unsigned EN_PIN   = 5;

  // tier index 0 is the most urgent
  typedef enum logic [2:0] {
    T_LINE   = 3'd0,
    T_RXTO   = 3'd1,
    T_RXDATA = 3'd2,
    T_TX     = 3'd3,
    T_MODEM  = 3'd4,
    T_FLOW   = 3'd5,
    T_PIN    = 3'd6
  } tier_e;

  function automatic iir_code_t tier_code(input int unsigned idx);
    case (idx)
      0:       return CODE_LINE;
      1:       return CODE_RXTO;
      2:       return CODE_RXDATA;
      3:       return CODE_TX;
      4:       return CODE_MODEM;
      5:       return CODE_FLOW;
      default: return CODE_PIN;
    endcase
  endfunction

endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_r;

  // a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= 1'b0;
    else if (set_i) q_r <= 1'b1;
    else if (clr_i) q_r <= 1'b0;
  end

  assign q_o = q_r;

  // set priority over clear (shared by R6, R7, R8, R9)
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // clear takes effect next cycle when no set competes (also R7, R8)
  assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  // flag holds without a clear (R7 relies on this for Xoff)
  assert_hold_without_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
#(
  parameter int unsigned N = TIERS
) (
  input  logic [N-1:0] pend_i,
  output iir_code_t    code_o,
  output logic         any_o
);

  logic [N-1:0] gnt;

  // one-hot grant: a tier wins when nothing more urgent is pending
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_grant
      if (gi == 0) begin : g_top
        assign gnt[gi] = pend_i[gi];
      end else begin : g_rest
        assign gnt[gi] = pend_i[gi] & ~(|pend_i[gi-1:0]);
      end
    end
  endgenerate

  always_comb begin
    iir_code_t acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) acc = acc | tier_code(i);
    end
    any_o  = |pend_i;
    code_o = any_o ? acc : CODE_NONE;
  end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] irq_en,
  input  logic            fifo_en,
  input  logic            rx_overrun,
  input  logic            rx_err_any,
  input  logic            rx_timeout,
  input  logic            rx_ready,
  input  logic            rx_lvl_hit,
  input  logic            tx_empty,
  input  logic            tx_lvl_hit,
  input  logic            modem_chg,
  input  logic            xoff_det,
  input  logic            xon_det,
  input  logic            spchar_det,
  input  logic            cts_deassert,
  input  logic            rts_deassert,
  input  logic            iir_rd,
  input  logic            msr_rd,
  input  logic            flow_rd,
  output logic            irq_n,
  output logic [CODE_W-1:0] iir_code
);

  logic       modem_q, xoff_q, spc_q, pin_q;
  logic       spc_clr;
  logic       line_src, rxd_src, tx_src;
  logic [TIERS-1:0] pend;
  iir_code_t  code_w;
  logic       any_w;

  // level sources, mode-selected
  assign line_src = rx_overrun | rx_err_any;
  assign rxd_src  = fifo_en ? rx_lvl_hit : rx_ready;
  assign tx_src   = fifo_en ? tx_lvl_hit : tx_empty;

  // special character clears only when its code is being shown
  assign spc_clr = iir_rd && (code_w == CODE_FLOW);

  uirq_sticky u_modem (.clk(clk), .rst_n(rst_n), .set_i(modem_chg),
                       .clr_i(msr_rd),  .q_o(modem_q));
  uirq_sticky u_xoff  (.clk(clk), .rst_n(rst_n), .set_i(xoff_det),
                       .clr_i(xon_det), .q_o(xoff_q));
  uirq_sticky u_spc   (.clk(clk), .rst_n(rst_n), .set_i(spchar_det),
                       .clr_i(spc_clr), .q_o(spc_q));
  uirq_sticky u_pin   (.clk(clk), .rst_n(rst_n), .set_i(cts_deassert | rts_deassert),
                       .clr_i(flow_rd), .q_o(pin_q));

  always_comb begin
    pend         = '0;
    pend[T_LINE]   = line_src        & irq_en[EN_LINE];
    pend[T_RXTO]   = rx_timeout      & irq_en[EN_RX];
    pend[T_RXDATA] = rxd_src         & irq_en[EN_RX];
    pend[T_TX]     = tx_src          & irq_en[EN_TX];
    pend[T_MODEM]  = modem_q         & irq_en[EN_MODEM];
    pend[T_FLOW]   = (xoff_q | spc_q) & irq_en[EN_FLOW];
    pend[T_PIN]    = pin_q           & irq_en[EN_PIN];
  end

  uirq_prio #(.N(TIERS)) u_prio (
    .pend_i (pend),
    .code_o (code_w),
    .any_o  (any_w)
  );

  assign irq_n    = ~any_w;
  assign iir_code = code_w;

  assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n |-> (iir_code == CODE_NONE));

  assert_pin_matches_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (iir_code != CODE_NONE));

  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[EN_LINE] && (rx_overrun || rx_err_any)) |-> (iir_code == CODE_LINE));

  assert_timeout_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[EN_RX] && rx_timeout && !(irq_en[EN_LINE] && (rx_overrun || rx_err_any)))
      |-> (iir_code == CODE_RXTO));

  assert_disabled_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> irq_n);

  assert_special_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spc_q && iir_rd && (iir_code != CODE_FLOW) && !spchar_det) |=> spc_q);

endmodule

// File: tb/uart_irq_arbiter_tb.sv
module uart_irq_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] irq_en = '0;
  logic fifo_en = 0, rx_overrun = 0, rx_err_any = 0, rx_timeout = 0;
  logic rx_ready = 0, rx_lvl_hit = 0, tx_empty = 0, tx_lvl_hit = 0;
  logic modem_chg = 0, xoff_det = 0, xon_det = 0, spchar_det = 0;
  logic cts_deassert = 0, rts_deassert = 0;
  logic iir_rd = 0, msr_rd = 0, flow_rd = 0;
  logic       irq_n;
  logic [5:0] iir_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .fifo_en(fifo_en),
    .rx_overrun(rx_overrun), .rx_err_any(rx_err_any), .rx_timeout(rx_timeout),
    .rx_ready(rx_ready), .rx_lvl_hit(rx_lvl_hit), .tx_empty(tx_empty),
    .tx_lvl_hit(tx_lvl_hit), .modem_chg(modem_chg), .xoff_det(xoff_det),
    .xon_det(xon_det), .spchar_det(spchar_det), .cts_deassert(cts_deassert),
    .rts_deassert(rts_deassert), .iir_rd(iir_rd), .msr_rd(msr_rd),
    .flow_rd(flow_rd), .irq_n(irq_n), .iir_code(iir_code)
  );

  // {req[3:0], en[5:0], fifo_en, ovr, err, to, rdy, lvl, txe, txl, code[5:0]}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  6'b111111, 8'b00000000, 6'b000001},  // R1 idle
    {4'd2,  6'b111111, 8'b01000000, 6'b000110},  // R2 overrun
    {4'd2,  6'b111111, 8'b00111010, 6'b000110},  // R2 err_any beats all
    {4'd3,  6'b111111, 8'b00011010, 6'b001100},  // R3 timeout over data
    {4'd4,  6'b111111, 8'b00001000, 6'b000100},  // R4 rx_ready, no FIFO
    {4'd4,  6'b111111, 8'b10001000, 6'b000001},  // R4 rx_ready ignored in FIFO mode
    {4'd4,  6'b111111, 8'b10000100, 6'b000100},  // R4 level hit in FIFO mode
    {4'd4,  6'b111111, 8'b00000100, 6'b000001},  // R4 level hit ignored without FIFO
    {4'd5,  6'b111111, 8'b00000010, 6'b000010},  // R5 tx_empty, no FIFO
    {4'd5,  6'b111111, 8'b10000010, 6'b000001},  // R5 tx_empty ignored in FIFO mode
    {4'd5,  6'b111111, 8'b10000101, 6'b000100},  // R5 rx data above tx
    {4'd5,  6'b111111, 8'b10000001, 6'b000010},  // R5 tx level in FIFO mode
    {4'd10, 6'b111110, 8'b01000010, 6'b000010},  // R10 line disabled
    {4'd10, 6'b000000, 8'b01010010, 6'b000001},  // R10 all disabled
    {4'd10, 6'b111101, 8'b00011000, 6'b000001}   // R10 rx group disabled
  };

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (iir_code !== exp || irq_n !== (exp == 6'b000001)) begin
      errors++;
      $display("FAIL %s: code=%b irq_n=%b expected code=%b irq_n=%b",
               req, iir_code, irq_n, exp, (exp == 6'b000001));
    end
  endtask

  // inputs change 2 ns after a rising edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [23:0] v;
    #1;
    chk("R1 in reset", 6'b000001);
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 after reset", 6'b000001);

    // vector walk over level sources (R11: same-cycle combinational)
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      irq_en = v[19:14];
      {fifo_en, rx_overrun, rx_err_any, rx_timeout,
       rx_ready, rx_lvl_hit, tx_empty, tx_lvl_hit} = v[13:6];
      #1;
      chk($sformatf("R%0d vector %0d", v[23:20], i), v[5:0]);
      step();
    end
    {fifo_en, rx_overrun, rx_err_any, rx_timeout,
     rx_ready, rx_lvl_hit, tx_empty, tx_lvl_hit} = '0;
    irq_en = 6'b111111;
    step();

    // R6 modem flag
    modem_chg = 1; #1;
    chk("R11 sticky not immediate", 6'b000001);
    step(); modem_chg = 0;
    chk("R6 modem set", 6'b000000);
    modem_chg = 1; msr_rd = 1; step(); modem_chg = 0; msr_rd = 0;
    chk("R6 set wins over read", 6'b000000);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R6 read clears", 6'b000001);

    // R7 Xoff flag
    xoff_det = 1; step(); xoff_det = 0;
    chk("R7 xoff set", 6'b010000);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R7 iir read keeps xoff", 6'b010000);
    xon_det = 1; step(); xon_det = 0;
    chk("R7 xon clears", 6'b000001);

    // R8 special character flag
    spchar_det = 1; step(); spchar_det = 0;
    chk("R8 special set", 6'b010000);
    tx_empty = 1; #1;
    chk("R8 tx shown above special", 6'b000010);
    iir_rd = 1; step(); iir_rd = 0;
    tx_empty = 0; #1;
    chk("R8 hidden read keeps special", 6'b010000);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R8 shown read clears", 6'b000001);

    // R9 CTS/RTS flag
    cts_deassert = 1; step(); cts_deassert = 0;
    chk("R9 cts set", 6'b100000);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R9 other read keeps", 6'b100000);
    flow_rd = 1; step(); flow_rd = 0;
    chk("R9 flow read clears", 6'b000001);
    rts_deassert = 1; step(); rts_deassert = 0;
    chk("R9 rts set", 6'b100000);
    flow_rd = 1; step(); flow_rd = 0;
    chk("R9 rts cleared", 6'b000001);

    // R10 disabled sticky still records
    irq_en = 6'b110111;
    modem_chg = 1; step(); modem_chg = 0;
    chk("R10 disabled modem hidden", 6'b000001);
    irq_en = 6'b111111; #1;
    chk("R10 enabled modem shown", 6'b000000);
    cts_deassert = 1; step(); cts_deassert = 0;
    chk("R6 modem above cts", 6'b000000);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R9 cts after modem read", 6'b100000);
    flow_rd = 1; step(); flow_rd = 0;
    chk("R1 back to idle", 6'b000001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule